// File: doc/BRIEF.md
# Bank Row Open Timer

This block keeps track of a single memory bank, which is either idle or holding one open row. When the bank is activated it loads a programmable minimum active time and counts it down. Until that time has run out, the bank may not be precharged, because closing the row too early would damage the data being written back from the sense amplifiers. The block raises a precharge-allowed flag once the window has elapsed and drives the precharge command strobe itself.

Two closing policies are available through a parameter. In closed-page mode, the row is shut automatically as soon as the window ends. The window is the only thing that keeps a speculatively opened row alive, so a read that lands inside it hits the row without a reopen. A read that arrives in the very cycle of expiry wins, and the precharge slips by one cycle. In open-page mode, the row stays open until an external precharge request arrives. A request made before expiry is remembered and carried out at expiry.

An activate that reaches an already-open bank is dropped and reported on a one-cycle violation flag.

Top module: `bank_row_timer`

## Requirements
- R1: An activate while the bank is idle opens the row; `row_open_o` is 1 in the cycle after the activate is sampled.
- R2: With T being `tras_i` sampled at the activate, `pre_ok_o` is 0 for the first max(T,1)-1 cycles after the activate cycle and 1 in cycle max(T,1) after it. Changes to `tras_i` after the activate have no effect on that row.
- R3: With CLOSE_PAGE=1, `pre_o` pulses in the first cycle in which `pre_ok_o` is 1 and `rd_i` is 0. The bank is idle in the next cycle.
- R4: A read in the cycle in which the window expires is accepted, and the precharge is deferred by one cycle. A read earlier in the window hits the open row and does not move the precharge.
- R5: With CLOSE_PAGE=0, the row stays open until `pre_req_i` is seen. A request before expiry is held and issued in the expiry cycle. A request at or after expiry is issued in the same cycle, unless a read is present then.
- R6: An activate while a row is open is ignored: `viol_o` is 1 for exactly the next cycle, and the row and its timer are unchanged.
- R7: A read or precharge request while the bank is idle has no effect: no `pre_o`, no state change, and no request is left pending for a later row.
- R8: After reset the bank is idle and `pre_ok_o`, `pre_o` and `viol_o` are 0.
- R9: `pre_o` is never 1 while `pre_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Row activate strobe |
| rd_i | input | 1 | Column read strobe |
| pre_req_i | input | 1 | External precharge request |
| tras_i | input | TW (8) | Minimum active time in cycles, sampled at activate |
| pre_ok_o | output | 1 | Precharge allowed (row open and window elapsed) |
| pre_o | output | 1 | Precharge issue strobe |
| row_open_o | output | 1 | Bank state: 1 = row open |
| viol_o | output | 1 | One-cycle flag for an activate to an open bank |

## Verification
The closed-page instance is opened with window values 0, 1, 3, 5 and 255. Comparing their precharge cycles separates correct counting from off-by-one loading and from saturation at the ends of the range. Reads placed inside the window and exactly at expiry show the difference between a row hit and a deferred close. A second activate mid-window checks that the timer is neither reloaded nor restarted. On the open-page instance, requests before, at and after expiry, including one that collides with a read, show whether requests are held, issued at once or deferred. Requests and reads made to an idle bank show whether a stale pending state leaks into the next row.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic {
    BANK_IDLE = 1'b0,
    BANK_OPEN = 1'b1
  } bank_state_e;
endpackage

// File: rtl/brt_active_timer.sv
module brt_active_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] value_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // The activate cycle itself counts as the first cycle of the window
  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    if (load_i)
      cnt_d = (value_i == '0) ? '0 : TW'(value_i - 1'b1);
    else
      cnt_d = TW'(cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/brt_close_ctl.sv
module brt_close_ctl #(
  parameter bit CLOSE_PAGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic expired_i,
  input  logic rd_i,
  input  logic req_i,
  output logic pre_o
);
  logic pend_q, pend_d, pend_en;
  logic close_want;

  assign close_want = CLOSE_PAGE | pend_q | req_i;
  // A read being accepted always wins over closing the row
  assign pre_o      = open_i & expired_i & ~rd_i & close_want;

  always_comb begin
    pend_en = pre_o | (open_i & req_i);
    pend_d  = ~pre_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (pend_en)
      pend_q <= pend_d;
  end

  a_r7_pend_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/bank_row_timer.sv
module bank_row_timer #(
  parameter int TW         = 8,
  parameter bit CLOSE_PAGE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          pre_req_i,
  input  logic [TW-1:0] tras_i,
  output logic          pre_ok_o,
  output logic          pre_o,
  output logic          row_open_o,
  output logic          viol_o
);
  import brt_pkg::*;

  bank_state_e st_q, st_d;
  logic        is_open, act_ok, act_bad, expired;
  logic        viol_q;

  assign is_open = (st_q == BANK_OPEN);
  assign act_ok  = act_i & ~is_open;
  assign act_bad = act_i & is_open;

  brt_active_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (act_ok),
    .value_i   (tras_i),
    .expired_o (expired)
  );

  brt_close_ctl #(.CLOSE_PAGE(CLOSE_PAGE)) u_close (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_i    (is_open),
    .expired_i (expired),
    .rd_i      (rd_i),
    .req_i     (pre_req_i),
    .pre_o     (pre_o)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      BANK_IDLE: if (act_i) st_d = BANK_OPEN;
      BANK_OPEN: if (pre_o) st_d = BANK_IDLE;
      default:   st_d = BANK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BANK_IDLE;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      viol_q <= act_bad;
    end
  end

  assign row_open_o = is_open;
  assign pre_ok_o   = is_open & expired;
  assign viol_o     = viol_q;

  a_r1_open_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_open_o) |-> $past(act_i));
  a_r9_pre_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    pre_o |-> pre_ok_o);
  a_r4_read_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> !pre_o);
  a_r3_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_o |=> !row_open_o);
  a_r6_bad_act_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open_o && act_i) |=> (viol_o && row_open_o));

  generate
    if (CLOSE_PAGE) begin : g_closed
      a_r3_auto_close: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok_o && !rd_i) |-> pre_o);
    end else begin : g_open
      a_r5_no_unasked_close: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok_o && !pre_req_i && !$past(pre_req_i) && !$past(row_open_o)) |-> !pre_o);
    end
  endgenerate
endmodule

// File: tb/sim_bank_row_timer.sv
`timescale 1ns/1ps
module sim_bank_row_timer;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act [2];
  logic       rd  [2];
  logic       req [2];
  logic [7:0] tras [2];
  logic       pre_ok [2];
  logic       pre [2];
  logic       row_open [2];
  logic       viol [2];

  int cyc = 0;
  int nchecks = 0;
  int errors = 0;
  int q0[$];
  int q1[$];
  string t0[$];
  string t1[$];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_row_timer #(.TW(8), .CLOSE_PAGE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .act_i(act[0]), .rd_i(rd[0]), .pre_req_i(req[0]),
    .tras_i(tras[0]), .pre_ok_o(pre_ok[0]), .pre_o(pre[0]),
    .row_open_o(row_open[0]), .viol_o(viol[0]));

  bank_row_timer #(.TW(8), .CLOSE_PAGE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .act_i(act[1]), .rd_i(rd[1]), .pre_req_i(req[1]),
    .tras_i(tras[1]), .pre_ok_o(pre_ok[1]), .pre_o(pre[1]),
    .row_open_o(row_open[1]), .viol_o(viol[1]));

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    nchecks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, actual, expected, cyc);
    end
  endtask

  // Monitor: pops the expected precharge cycle whenever a strobe appears
  always @(negedge clk) begin
    #5;
    for (int s = 0; s < 2; s++) begin
      if (rst_n && pre[s]) begin
        int e;
        string tg;
        if (s == 0 && q0.size() > 0) begin e = q0.pop_front(); tg = t0.pop_front(); end
        else if (s == 1 && q1.size() > 0) begin e = q1.pop_front(); tg = t1.pop_front(); end
        else begin e = -1; tg = "R7 unexpected precharge"; end
        check(e == cyc, tg, cyc, e);
      end
    end
  end

  // Driver: opens a row on instance s and pushes the expected close cycle
  task automatic run_row(input int s, input int t, input int rd_at, input int req_at,
                         input int viol_at, input string tag);
    int c = cyc;
    int m = (t == 0) ? 1 : t;
    int er;
    if (s == 0) er = m;
    else er = (req_at > m) ? req_at : m;
    if (rd_at == er) er++;              // R4: read at the close slot defers it
    if (s == 0) begin q0.push_back(c + er); t0.push_back(tag); end
    else begin q1.push_back(c + er); t1.push_back(tag); end
    act[s] = 1'b1;
    tras[s] = 8'(t);
    for (int k = 1; k <= er + 1; k++) begin
      @(negedge clk);
      act[s]  = (k == viol_at);
      tras[s] = 8'd200;                 // R2: late changes must not matter
      rd[s]   = (k == rd_at);
      req[s]  = (k == req_at);
      #5;
      if (k == 1) check(row_open[s] == 1'b1, "R1 row open after activate", row_open[s], 1);
      if (k == m - 1) check(pre_ok[s] == 1'b0, "R2 precharge blocked early", pre_ok[s], 0);
      if (k == m) check(pre_ok[s] == 1'b1, "R2 precharge allowed at window end", pre_ok[s], 1);
      if (k == viol_at + 1) begin
        check(viol[s] == 1'b1, "R6 violation flag", viol[s], 1);
        check(row_open[s] == 1'b1, "R6 row kept open", row_open[s], 1);
      end
      if (viol_at > 0 && k == viol_at + 2) check(viol[s] == 1'b0, "R6 flag one cycle", viol[s], 0);
      if (k == er + 1) check(row_open[s] == 1'b0, "R3 bank idle after precharge", row_open[s], 0);
    end
    @(negedge clk);
    act[s] = 1'b0; rd[s] = 1'b0; req[s] = 1'b0; tras[s] = 8'd0;
  endtask

  task automatic idle_pokes(input int s);
    for (int k = 0; k < 3; k++) begin
      rd[s] = 1'b1; req[s] = 1'b1;
      @(negedge clk);
      #5;
      check(row_open[s] == 1'b0, "R7 idle read/request ignored", row_open[s], 0);
    end
    rd[s] = 1'b0; req[s] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      act[s] = 1'b0; rd[s] = 1'b0; req[s] = 1'b0; tras[s] = 8'd0;
    end
    repeat (3) @(negedge clk);
    #5;
    for (int s = 0; s < 2; s++) begin
      check(row_open[s] == 1'b0, "R8 reset idle", row_open[s], 0);
      check(pre_ok[s] == 1'b0, "R8 reset pre_ok low", pre_ok[s], 0);
      check(pre[s] == 1'b0, "R8 reset pre low", pre[s], 0);
      check(viol[s] == 1'b0, "R8 reset viol low", viol[s], 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Closed-page instance
    run_row(0, 5, -1, -1, -1, "R3 auto close T=5");
    run_row(0, 0, -1, -1, -1, "R2 T=0 closes after one cycle");
    run_row(0, 1, -1, -1, -1, "R2 T=1");
    run_row(0, 4, 2, -1, -1, "R4 early read is a row hit");
    run_row(0, 4, 4, -1, -1, "R4 read at expiry defers close");
    run_row(0, 6, -1, -1, 2, "R6 second activate ignored");
    run_row(0, 3, -1, 1, -1, "R3 request before expiry");
    idle_pokes(0);
    run_row(0, 255, -1, -1, -1, "R2 T=255");

    // Open-page instance
    run_row(1, 4, -1, 2, -1, "R5 early request held");
    run_row(1, 3, -1, 6, -1, "R5 late request immediate");
    run_row(1, 3, 3, 3, -1, "R5 request with read deferred");
    idle_pokes(1);
    run_row(1, 2, -1, 7, -1, "R7 no stale request");

    repeat (4) @(negedge clk);
    check(q0.size() == 0, "R3 missing precharge", q0.size(), 0);
    check(q1.size() == 0, "R5 missing precharge", q1.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    nchecks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end
endmodule